// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

A single-port synchronous memory whose write protocol is late write: address and control are sampled on one rising clock edge and the matching write data on the next rising edge. Each word is split into byte lanes, each with its own active-low enable. The lane enables are sampled together with the write strobe, and any subset of them may be active. When no lane is enabled, the write cycle is an abort and the array is left unchanged.

A read samples the address on a rising edge and loads the addressed word into the output register on that same edge. The word is therefore valid for the whole following cycle. A read that hits the word whose late data is being committed on the same edge returns the merged result. Chip select high makes the cycle idle.

Top module: `lw_sram`

## Requirements
- R1: A write cycle starts when `sel_n` and `wen_n` are both low at a rising edge. Its data is taken from `wdata` at the next rising edge.
- R2: Only the lanes whose `ben_n` bit is low at the starting edge are written. Lane i occupies `wdata`/`rdata` bits [9i+8:9i], and the other lanes keep their old contents.
- R3: A write cycle with all four `ben_n` bits high changes no word.
- R4: With `sel_n` low and `wen_n` high at a rising edge, `rdata` takes the word at `addr` on that edge and `ben_n` is ignored.
- R5: With `sel_n` high, no read or write takes place and `rdata` holds its value. `rdata` also holds through write cycles.
- R6: A read whose address equals that of a write whose data is taken on the same edge returns the word with the new lanes merged in.
- R7: While `rst_n` is low, `rdata` and every word are cleared to zero.
- R8: A write may start on the same edge that takes the data of the previous write, so writes can be issued on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| wen_n | input | 1 | Write strobe, active low; high selects a read |
| ben_n | input | 4 | Lane enables, active low, bit i controls lane i |
| addr | input | AW | Word address |
| wdata | input | 36 | Late write data, taken one edge after its address |
| rdata | output | 36 | Registered read data |

## Verification
The assertions assume that `sel_n`, `wen_n` and `ben_n` are known at every rising edge after reset. They also assume that `rst_n` is held low for at least one edge before any access. The bench drives every control input from bounded random values or directed patterns, never X, and keeps select high throughout reset. Random addresses are kept to a small window so that reads often hit the word whose late data is in flight.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n,
  input  logic                wen_n,
  input  logic [LANES-1:0]    ben_n,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic             pend_vld;
  logic [AW-1:0]    pend_addr;
  logic [LANES-1:0] pend_ben_n;
  logic [DW-1:0]    merged;

  wire do_wr = !sel_n && !wen_n && !(&ben_n);
  wire do_rd = !sel_n && wen_n;
  wire hit   = pend_vld && (pend_addr == addr);

  always_comb begin
    merged = mem[pend_addr];
    for (int i = 0; i < LANES; i++)
      if (!pend_ben_n[i]) merged[i*LW +: LW] = wdata[i*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_addr  <= '0;
      pend_ben_n <= '1;
      rdata      <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      pend_vld   <= do_wr;
      pend_addr  <= addr;
      pend_ben_n <= ben_n;
      if (pend_vld) mem[pend_addr] <= merged;
      if (do_rd) rdata <= hit ? merged : mem[addr];
    end
  end
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int LANES = 4,
  parameter int DW    = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             wen_n,
  input logic [LANES-1:0] ben_n,
  input logic [DW-1:0]    rdata,
  input logic             pend_vld
);
  p_reset_clear_r7: assert property (@(posedge clk) !rst_n |=> rdata == '0);

  p_deselect_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(rdata));

  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wen_n) |=> $stable(rdata));

  p_late_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wen_n && !(&ben_n)) |=> pend_vld);

  p_abort_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wen_n && (&ben_n)) |=> !pend_vld);

  p_no_slot_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || wen_n) |=> !pend_vld);
endmodule

bind lw_sram lw_sram_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wen_n(wen_n),
  .ben_n(ben_n), .rdata(rdata), .pend_vld(pend_vld)
);

// File: tb/sim_lw_sram.sv
module sim_lw_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        wen_n = 1'b1;
  logic [3:0]  ben_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;

  int n_chk = 0;
  int n_fail = 0;

  logic [35:0]   mdl [DEPTH];
  logic          m_pv;
  logic [AW-1:0] m_pa;
  logic [3:0]    m_pb;
  logic [35:0]   m_rd;

  lw_sram #(.AW(AW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [35:0] lane_merge(logic [35:0] old, logic [35:0] nw, logic [3:0] bn);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (!bn[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic w, logic [3:0] b, logic [AW-1:0] a, logic [35:0] d, string tag);
    logic fwd;
    @(negedge clk);
    sel_n = s; wen_n = w; ben_n = b; addr = a; wdata = d;
    @(posedge clk);
    #1;
    fwd = m_pv && (m_pa == a);
    if (!s && w) m_rd = fwd ? lane_merge(mdl[m_pa], d, m_pb) : mdl[a];
    if (m_pv) mdl[m_pa] = lane_merge(mdl[m_pa], d, m_pb);
    m_pv = !s && !w && !(&b);
    m_pa = a; m_pb = b;
    check((!s && w && fwd) ? {tag, "/R6"} : tag, rdata, m_rd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not end");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    m_pv = 0; m_pa = '0; m_pb = 4'hF; m_rd = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset rdata", rdata, 36'h0);
    @(negedge clk); rst_n = 1'b1;

    cyc(0, 1, 4'h0, 6'd5, '0, "R7 word cleared");
    cyc(0, 0, 4'h0, 6'd1, '0, "R1 full write start");
    cyc(1, 1, 4'hF, 6'd9, 36'hA_BCDE_F012, "R1 data edge");
    cyc(0, 1, 4'h0, 6'd1, '0, "R1 full readback");
    cyc(0, 0, 4'hB, 6'd1, '0, "R2 lane2 write");
    cyc(1, 1, 4'hF, 6'd0, 36'hF_FFFF_FFFF, "R2 data");
    cyc(0, 1, 4'hF, 6'd1, '0, "R2 lane2 only");
    cyc(0, 0, 4'hF, 6'd1, '0, "R3 abort start");
    cyc(1, 1, 4'hF, 6'd0, 36'h0, "R3 abort data");
    cyc(0, 1, 4'h0, 6'd1, '0, "R3 word unchanged");
    cyc(0, 0, 4'h6, 6'd2, '0, "R8 write a");
    cyc(0, 0, 4'h0, 6'd3, 36'h1_2345_6789, "R8 write b");
    cyc(0, 1, 4'h5, 6'd3, 36'h9_8765_4321, "R8 forward b");
    cyc(0, 1, 4'hA, 6'd2, '0, "R8 read a");
    cyc(1, 0, 4'h0, 6'd2, '0, "R5 deselect");
    cyc(0, 0, 4'h0, 6'd4, '0, "R5 write hold");
    cyc(0, 1, 4'h3, 6'd4, 36'h5_5555_5555, "R6 read during commit");

    for (int k = 0; k < 3000; k++) begin
      automatic logic s = ($urandom % 5) == 0;
      automatic logic w = $urandom % 2;
      automatic logic [3:0] b = ($urandom % 6 == 0) ? 4'hF : 4'($urandom);
      automatic logic [AW-1:0] a = AW'($urandom % 8);
      automatic logic [35:0] d = {4'($urandom), 32'($urandom)};
      cyc(s, w, b, a, d, s ? "R5 random" : (w ? "R4 random" : "R2 random"));
    end

    for (int i = 0; i < DEPTH; i++) cyc(0, 1, 4'($urandom), AW'(i), '0, "R4 final sweep");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule